// File: doc/BRIEF.md
# Code Memory Lock Guard

This block turns three non-volatile lock bits into access decisions for an embedded code memory. Four kinds of request reach it as single-cycle strobes: a code-table read issued by code running from external program memory, a programming write, a verify read and an instruction fetch from external memory. One cycle after each strobe the block raises either a grant or a deny for that request. A denied verify read returns an all-ones byte in place of the memory data.

The protection is cumulative. Each further lock bit, taken in order from the first, adds one restriction on top of the ones before it. The block also keeps a latch of the external-access pin level, which it samples only while reset is held. When at least the first lock bit is programmed, it flags any disagreement between that stored level and the live pin. Until the first reset, the latch holds an arbitrary value.

Top module: `code_lock_guard`

## Requirements
- R1: `lock_n[i]` reads 0 when lock bit i is programmed and 1 when it is unprogrammed. Bit 0 is the first lock bit. The protection level is the number of consecutive programmed bits counted up from bit 0, so a programmed bit above an unprogrammed one adds nothing.
- R2: At level 0 every request is granted.
- R3: At level 1 and above, code-table reads and programming writes are denied.
- R4: At level 2 and above, verify reads are also denied.
- R5: At level 3, external instruction fetches are also denied.
- R6: For each request kind, the grant or the deny (exactly one of them) is high in the cycle after the strobe. Both stay low in the cycle after a cycle with no strobe. Both are low while reset is held.
- R7: `vfy_data_out` shows the `vfy_data_in` byte sampled with a granted verify strobe in the following cycle. At all other times, including after a denied verify and during reset, it shows 8'hFF.
- R8: `ea_latched` takes the level of `ea_pin` on each clock edge while `rst_n` is low. After reset is released it keeps that value whatever the pin does.
- R9: `ea_mismatch` is high exactly when reset is released, the level is 1 or more, and `ea_latched` differs from `ea_pin`. It responds to the pin within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also the sampling window of the pin latch |
| lock_n | input | 3 | Lock bits, 0 = programmed |
| ea_pin | input | 1 | Live external-access pin level |
| req_table | input | 1 | Code-table read strobe from external code |
| req_prog | input | 1 | Programming write strobe |
| req_verify | input | 1 | Verify read strobe |
| req_xfetch | input | 1 | External instruction fetch strobe |
| vfy_data_in | input | 8 | Code memory byte for a verify read |
| gnt_table | output | 1 | Code-table read granted |
| deny_table | output | 1 | Code-table read denied |
| gnt_prog | output | 1 | Programming write granted |
| deny_prog | output | 1 | Programming write denied |
| gnt_verify | output | 1 | Verify read granted |
| deny_verify | output | 1 | Verify read denied |
| gnt_xfetch | output | 1 | External fetch granted |
| deny_xfetch | output | 1 | External fetch denied |
| vfy_data_out | output | 8 | Verify read data, or 8'hFF |
| ea_latched | output | 1 | Pin level captured during reset |
| ea_mismatch | output | 1 | Captured and live pin levels disagree while locked |

## Verification
Every cycle, the assertions check the per-level deny rules against the decoded level, the quiet outputs after a cycle with no strobe, the all-ones data behind every denied verify, the stability of the pin latch once out of reset, and the absence of a mismatch flag at level 0. Several behaviours only the bench's scenarios can show: the decoding of all eight lock codes, including the ones with gaps; the exact data passed through on granted verifies; the latch taking a new value in a second reset; and the mismatch flag following the live pin in both directions.

// File: rtl/lock_guard_pkg.sv
`timescale 1ns/1ps
package lock_guard_pkg;

  localparam int unsigned N_REQ = 4;

  typedef enum logic [1:0] {
    REQ_TABLE  = 2'd0,
    REQ_PROG   = 2'd1,
    REQ_VERIFY = 2'd2,
    REQ_XFETCH = 2'd3
  } req_kind_e;

  // Lowest protection level at which a request kind is refused.
  function automatic int unsigned deny_floor(input int unsigned kind);
    case (kind)
      REQ_TABLE:  return 1;
      REQ_PROG:   return 1;
      REQ_VERIFY: return 2;
      default:    return 3;
    endcase
  endfunction

endpackage

// File: rtl/lock_level_decode.sv
`timescale 1ns/1ps
module lock_level_decode #(
  parameter int unsigned N_LOCK = 3,
  localparam int unsigned LVL_W = $clog2(N_LOCK + 1)
) (
  input  logic [N_LOCK-1:0] lock_n,
  output logic [LVL_W-1:0]  level
);

  // Count programmed (0) bits from bit 0 up to the first unprogrammed one.
  function automatic logic [LVL_W-1:0] run_depth(input logic [N_LOCK-1:0] bits);
    logic [LVL_W-1:0] depth;
    logic             broken;
    depth  = '0;
    broken = 1'b0;
    for (int i = 0; i < N_LOCK; i++) begin
      if (bits[i]) broken = 1'b1;
      else if (!broken) depth = LVL_W'(i + 1);
    end
    return depth;
  endfunction

  always_comb level = run_depth(lock_n);

endmodule

// File: rtl/ea_sample_latch.sv
`timescale 1ns/1ps
module ea_sample_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ea_pin,
  output logic ea_held
);

  // No reset value on purpose: arbitrary until the first reset window.
  always_ff @(posedge clk) begin
    if (!rst_n) ea_held <= ea_pin;
  end

endmodule

// File: rtl/req_gate.sv
`timescale 1ns/1ps
module req_gate #(
  parameter int unsigned LVL_W = 2,
  parameter int unsigned FLOOR = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [LVL_W-1:0] level,
  output logic             permit,
  output logic             gnt,
  output logic             deny
);

  always_comb permit = (int'(level) < FLOOR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt  <= 1'b0;
      deny <= 1'b0;
    end else begin
      gnt  <= req & permit;
      deny <= req & ~permit;
    end
  end

endmodule

// File: rtl/code_lock_guard.sv
`timescale 1ns/1ps
module code_lock_guard #(
  parameter int unsigned N_LOCK = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LOCK-1:0] lock_n,
  input  logic              ea_pin,
  input  logic              req_table,
  input  logic              req_prog,
  input  logic              req_verify,
  input  logic              req_xfetch,
  input  logic [DATA_W-1:0] vfy_data_in,
  output logic              gnt_table,
  output logic              deny_table,
  output logic              gnt_prog,
  output logic              deny_prog,
  output logic              gnt_verify,
  output logic              deny_verify,
  output logic              gnt_xfetch,
  output logic              deny_xfetch,
  output logic [DATA_W-1:0] vfy_data_out,
  output logic              ea_latched,
  output logic              ea_mismatch
);
  import lock_guard_pkg::*;

  localparam int unsigned LVL_W = $clog2(N_LOCK + 1);

  logic [LVL_W-1:0] lock_level;
  logic [N_REQ-1:0] req_vec, permit_vec, gnt_vec, deny_vec;
  logic             ea_held;

  lock_level_decode #(.N_LOCK(N_LOCK)) u_decode (
    .lock_n (lock_n),
    .level  (lock_level)
  );

  ea_sample_latch u_ea (
    .clk     (clk),
    .rst_n   (rst_n),
    .ea_pin  (ea_pin),
    .ea_held (ea_held)
  );

  always_comb begin
    req_vec             = '0;
    req_vec[REQ_TABLE]  = req_table;
    req_vec[REQ_PROG]   = req_prog;
    req_vec[REQ_VERIFY] = req_verify;
    req_vec[REQ_XFETCH] = req_xfetch;
  end

  for (genvar k = 0; k < N_REQ; k++) begin : g_gate
    req_gate #(.LVL_W(LVL_W), .FLOOR(deny_floor(k))) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req_vec[k]),
      .level  (lock_level),
      .permit (permit_vec[k]),
      .gnt    (gnt_vec[k]),
      .deny   (deny_vec[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vfy_data_out <= '1;
    else if (req_verify && permit_vec[REQ_VERIFY]) vfy_data_out <= vfy_data_in;
    else vfy_data_out <= '1;
  end

  assign gnt_table   = gnt_vec[REQ_TABLE];
  assign deny_table  = deny_vec[REQ_TABLE];
  assign gnt_prog    = gnt_vec[REQ_PROG];
  assign deny_prog   = deny_vec[REQ_PROG];
  assign gnt_verify  = gnt_vec[REQ_VERIFY];
  assign deny_verify = deny_vec[REQ_VERIFY];
  assign gnt_xfetch  = gnt_vec[REQ_XFETCH];
  assign deny_xfetch = deny_vec[REQ_XFETCH];
  assign ea_latched  = ea_held;
  assign ea_mismatch = rst_n && (lock_level != '0) && (ea_held != ea_pin);

endmodule

// File: rtl/lock_guard_checker.sv
`timescale 1ns/1ps
module lock_guard_checker #(
  parameter int unsigned LVL_W  = 2,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LVL_W-1:0]  lock_level,
  input logic              req_table,
  input logic              req_prog,
  input logic              req_verify,
  input logic              req_xfetch,
  input logic              gnt_prog,
  input logic              deny_table,
  input logic              deny_prog,
  input logic              gnt_verify,
  input logic              deny_verify,
  input logic              gnt_xfetch,
  input logic              deny_xfetch,
  input logic [DATA_W-1:0] vfy_data_out,
  input logic              ea_latched,
  input logic              ea_mismatch
);

  AST_OPEN_GRANTS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_level == '0 && req_xfetch) |=> gnt_xfetch);                       // R2
  AST_LOCKED_TABLE_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_level != '0 && req_table) |=> deny_table);                        // R3
  AST_LOCKED_PROG_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_level != '0 && req_prog) |=> (deny_prog && !gnt_prog));           // R3
  AST_VERIFY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lock_level) >= 2 && req_verify) |=> deny_verify);                 // R4
  AST_FETCH_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lock_level) >= 3 && req_xfetch) |=> deny_xfetch);                 // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_verify |=> (!gnt_verify && !deny_verify));                         // R6
  AST_DENIED_DATA_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    deny_verify |-> (vfy_data_out == '1));                                  // R7
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(ea_latched));                                          // R8
  AST_OPEN_NO_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_level == '0) |-> !ea_mismatch);                                   // R9

endmodule

bind code_lock_guard lock_guard_checker #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lock_level   (lock_level),
  .req_table    (req_table),
  .req_prog     (req_prog),
  .req_verify   (req_verify),
  .req_xfetch   (req_xfetch),
  .gnt_prog     (gnt_prog),
  .deny_table   (deny_table),
  .deny_prog    (deny_prog),
  .gnt_verify   (gnt_verify),
  .deny_verify  (deny_verify),
  .gnt_xfetch   (gnt_xfetch),
  .deny_xfetch  (deny_xfetch),
  .vfy_data_out (vfy_data_out),
  .ea_latched   (ea_latched),
  .ea_mismatch  (ea_mismatch)
);

// File: tb/code_lock_guard_test.sv
`timescale 1ns/1ps
module code_lock_guard_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] lock_n;
  logic       ea_pin;
  logic       req_table, req_prog, req_verify, req_xfetch;
  logic [7:0] vfy_data_in;
  logic       gnt_table, deny_table, gnt_prog, deny_prog;
  logic       gnt_verify, deny_verify, gnt_xfetch, deny_xfetch;
  logic [7:0] vfy_data_out;
  logic       ea_latched, ea_mismatch;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  code_lock_guard uut (
    .clk(clk), .rst_n(rst_n), .lock_n(lock_n), .ea_pin(ea_pin),
    .req_table(req_table), .req_prog(req_prog), .req_verify(req_verify),
    .req_xfetch(req_xfetch), .vfy_data_in(vfy_data_in),
    .gnt_table(gnt_table), .deny_table(deny_table),
    .gnt_prog(gnt_prog), .deny_prog(deny_prog),
    .gnt_verify(gnt_verify), .deny_verify(deny_verify),
    .gnt_xfetch(gnt_xfetch), .deny_xfetch(deny_xfetch),
    .vfy_data_out(vfy_data_out), .ea_latched(ea_latched),
    .ea_mismatch(ea_mismatch)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R1: level = run of programmed (0) bits from bit 0 upward.
  function automatic int exp_level(input logic [2:0] code);
    if (code[0]) return 0;
    if (code[1]) return 1;
    if (code[2]) return 2;
    return 3;
  endfunction

  task automatic report_and_end();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_reqs();
    req_table = 0; req_prog = 0; req_verify = 0; req_xfetch = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    report_and_end();
  end

  initial begin
    // Before the first reset the pin latch is unknown; it is not checked here.
    rst_n = 1'b0; lock_n = 3'b110; ea_pin = 1'b1; vfy_data_in = 8'h3C;
    idle_reqs();
    @(negedge clk);
    req_prog = 1; req_verify = 1;           // strobes during reset
    step(); step();
    chk({gnt_prog, deny_prog, gnt_verify, deny_verify} == 4'b0, "R6 reset clears",
        {gnt_prog, deny_prog, gnt_verify, deny_verify}, 0);
    chk(vfy_data_out == 8'hFF, "R7 reset data", vfy_data_out, 8'hFF);
    chk(ea_latched == 1'b1, "R8 sample in reset", ea_latched, 1);
    ea_pin = 1'b0;
    step();
    chk(ea_latched == 1'b0, "R8 follows pin in reset", ea_latched, 0);
    chk(ea_mismatch == 1'b0, "R9 quiet in reset", ea_mismatch, 0);
    ea_pin = 1'b1;
    step();
    idle_reqs();
    rst_n = 1'b1;
    step();
    chk({gnt_prog, deny_prog} == 2'b0, "R6 idle after reset", {gnt_prog, deny_prog}, 0);
    chk(ea_mismatch == 1'b0, "R9 agree", ea_mismatch, 0);
    ea_pin = 1'b0;
    step();
    chk(ea_latched == 1'b1, "R8 holds after release", ea_latched, 1);
    #1 chk(ea_mismatch == 1'b1, "R9 level1 disagree", ea_mismatch, 1);
    lock_n = 3'b111;
    #1 chk(ea_mismatch == 1'b0, "R9 level0 suppressed", ea_mismatch, 0);
    lock_n = 3'b011;                        // R1 gap: bit 2 alone is level 0
    #1 chk(ea_mismatch == 1'b0, "R1 R9 gap code is open", ea_mismatch, 0);
    lock_n = 3'b000;
    #1 chk(ea_mismatch == 1'b1, "R9 level3 disagree", ea_mismatch, 1);
    ea_pin = 1'b1;
    #1 chk(ea_mismatch == 1'b0, "R9 pin restored", ea_mismatch, 0);
    @(negedge clk);

    // Full sweep: every lock code against every strobe pattern.
    for (int code = 0; code < 8; code++) begin
      for (int pat = 0; pat < 16; pat++) begin
        int   lvl;
        logic exp_g, exp_d;
        logic [7:0] d;
        lock_n = 3'(code);
        {req_xfetch, req_verify, req_prog, req_table} = 4'(pat);
        d = 8'((code * 37 + pat * 11) ^ 8'h5A);
        vfy_data_in = d;
        lvl = exp_level(3'(code));
        step();
        // R2 R3 code-table read: refused from level 1
        exp_g = pat[0] && lvl < 1; exp_d = pat[0] && lvl >= 1;
        chk({gnt_table, deny_table} == {exp_g, exp_d}, "R3 R6 table",
            {gnt_table, deny_table}, {exp_g, exp_d});
        // R3 programming: refused from level 1
        exp_g = pat[1] && lvl < 1; exp_d = pat[1] && lvl >= 1;
        chk({gnt_prog, deny_prog} == {exp_g, exp_d}, "R3 R6 prog",
            {gnt_prog, deny_prog}, {exp_g, exp_d});
        // R4 verify: refused from level 2
        exp_g = pat[2] && lvl < 2; exp_d = pat[2] && lvl >= 2;
        chk({gnt_verify, deny_verify} == {exp_g, exp_d}, "R4 R6 verify",
            {gnt_verify, deny_verify}, {exp_g, exp_d});
        chk(vfy_data_out == (exp_g ? d : 8'hFF), "R7 verify data",
            vfy_data_out, exp_g ? d : 8'hFF);
        // R5 external fetch: refused at level 3; R2 open at level 0
        exp_g = pat[3] && lvl < 3; exp_d = pat[3] && lvl >= 3;
        chk({gnt_xfetch, deny_xfetch} == {exp_g, exp_d}, "R2 R5 R6 xfetch",
            {gnt_xfetch, deny_xfetch}, {exp_g, exp_d});
      end
    end
    idle_reqs();
    step();
    chk({gnt_table, deny_table, gnt_xfetch, deny_xfetch} == 4'b0, "R6 no strobe",
        {gnt_table, deny_table, gnt_xfetch, deny_xfetch}, 0);
    chk(vfy_data_out == 8'hFF, "R7 idle data", vfy_data_out, 8'hFF);

    // Second reset re-samples the pin at a new level.
    lock_n = 3'b100; ea_pin = 1'b0; rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    chk(ea_latched == 1'b0, "R8 resample", ea_latched, 0);
    chk(ea_mismatch == 1'b0, "R9 level2 agree", ea_mismatch, 0);
    ea_pin = 1'b1;
    step();
    chk(ea_latched == 1'b0, "R8 hold again", ea_latched, 0);
    chk(ea_mismatch == 1'b1, "R9 level2 disagree", ea_mismatch, 1);

    done = 1'b1;
    report_and_end();
  end

endmodule